// File: doc/BRIEF.md
# In-Order Putaway Commit Controller

This block sits between an in-order decoder and the result write-back point of a pipeline whose execution units may finish in any order. Each decoded instruction is given a tag, which is a slot in a circular tracking queue. Execution units report completion by tag. The controller then releases results for putaway strictly in program order, one per cycle, always from the oldest slot.

A mode input selects between two gating rules. In basic mode, a load/store puts away as soon as its execution has finished. In extended mode, a load/store must also have finished address generation and translation, so no later ALU result can put away ahead of an untranslated memory reference. A translation fault on a memory slot pulses a flush output with the faulting tag. All younger slots are discarded, and tag allocation restarts just after the faulting slot. The faulting slot never puts away. When it reaches the head, it is removed silently, so no state change happens after the faulting instruction.

Top module: `putaway_commit_ctrl`

## Requirements
- R1: After reset the queue is empty: `dec_ready`=1, `dec_tag`=0, `pa_valid`=0, `flush`=0.
- R2: Each accepted decode (`dec_valid` and `dec_ready`) is given tag `dec_tag`, which equals the previous accepted tag plus one modulo DEPTH. `dec_ready` is 0 while DEPTH slots are occupied, and `dec_valid` in that state allocates nothing.
- R3: At most one putaway is granted per cycle, and only for the oldest occupied slot. Granted tags follow allocation order, even when completions arrive out of order. A slot is granted only after its completion report has been recorded.
- R4: Completion and translate-done reports for tags that are not occupied are ignored. A slot allocated later under that tag does not inherit them.
- R5: With `ext_mode`=0, a memory slot at the head is granted once execution is complete. Translate status is not required.
- R6: With `ext_mode`=1, a memory slot at the head needs both its completion and its translate-done report. Younger slots, including ALU slots, wait behind it.
- R7: A fault report that is accepted makes `flush` high in the next cycle, with `exc_tag` equal to the faulting tag. Every younger slot is removed, and the next allocated tag is the faulting tag plus one.
- R8: A faulted slot is never granted. When it becomes the oldest slot, it is removed without `pa_valid`.
- R9: A fault report is ignored (no `flush`, no slot removed) if its tag is unoccupied, is not a memory slot, already has its translate-done recorded, is already faulted, or is the head slot being granted in that same cycle.
- R10: A decode presented in the same cycle as an accepted fault is discarded.
- R11: While the queue is empty, `pa_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 1 = translate status gates memory putaway |
| dec_valid | input | 1 | Decoder presents an instruction |
| dec_mem | input | 1 | Presented instruction is a load/store |
| dec_ready | output | 1 | A free slot is available |
| dec_tag | output | TAG_W | Tag given to the presented instruction |
| cmp_valid | input | 1 | Execution-complete report |
| cmp_tag | input | TAG_W | Tag of the completed instruction |
| xl_done_valid | input | 1 | Address generate and translate finished |
| xl_done_tag | input | TAG_W | Tag for the translate-done report |
| xl_fault_valid | input | 1 | Translation found a non-resident page |
| xl_fault_tag | input | TAG_W | Tag of the faulting instruction |
| pa_valid | output | 1 | Putaway granted this cycle |
| pa_tag | output | TAG_W | Tag being put away |
| flush | output | 1 | One-cycle exception/flush pulse |
| exc_tag | output | TAG_W | Tag that raised the exception |

## Verification
The main sweep fills the queue with many load/store versus ALU mixes and then reports completions and translations in odd-stride permutations. This separates true in-order release from release in completion order, and with the head wrapping between trials it also exercises tag wrap-around. Every mix runs in both modes, so a memory slot waiting for translation shows the difference between the basic and extended gating. Directed sequences then deliver faults on younger, head, ALU, unoccupied and already-translated slots, and combine a fault with a decode in the same cycle. These sequences tell apart faults that are accepted from faults that must be ignored, and check that no younger result escapes.

// File: rtl/pac_pkg.sv
package pac_pkg;
  typedef struct packed {
    logic vld;
    logic mem;
    logic exd;
    logic xld;
    logic flt;
  } slot_t;
endpackage

// File: rtl/pac_slot.sv
module pac_slot
  import pac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  alloc,
  input  logic  alloc_mem,
  input  logic  cmp_hit,
  input  logic  xl_hit,
  input  logic  flt_set,
  input  logic  kill,
  input  logic  retire,
  output slot_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (kill || retire) begin
      q <= '0;
    end else if (alloc) begin
      q <= '{vld: 1'b1, mem: alloc_mem, exd: 1'b0, xld: 1'b0, flt: 1'b0};
    end else if (q.vld) begin
      q.exd <= q.exd | cmp_hit;
      q.xld <= q.xld | xl_hit;
      q.flt <= q.flt | flt_set;
    end
  end

  a_r4_empty_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!q.vld && !alloc) |=> !q.vld);
  a_r7_kill_clears: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !q.vld);
endmodule

// File: rtl/pac_head_arb.sv
module pac_head_arb
  import pac_pkg::*;
(
  input  slot_t hs,
  input  logic  ext_mode,
  output logic  grant,
  output logic  drop
);
  logic mem_ok;
  always_comb begin
    mem_ok = !hs.mem || !ext_mode || hs.xld;
    grant  = hs.vld && hs.exd && !hs.flt && mem_ok;
    drop   = hs.vld && hs.flt;
  end
endmodule

// File: rtl/putaway_commit_ctrl.sv
module putaway_commit_ctrl
  import pac_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode,
  input  logic             dec_valid,
  input  logic             dec_mem,
  output logic             dec_ready,
  output logic [TAG_W-1:0] dec_tag,
  input  logic             cmp_valid,
  input  logic [TAG_W-1:0] cmp_tag,
  input  logic             xl_done_valid,
  input  logic [TAG_W-1:0] xl_done_tag,
  input  logic             xl_fault_valid,
  input  logic [TAG_W-1:0] xl_fault_tag,
  output logic             pa_valid,
  output logic [TAG_W-1:0] pa_tag,
  output logic             flush,
  output logic [TAG_W-1:0] exc_tag
);
  localparam int CNT_W = TAG_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  // distance from the oldest slot, modulo DEPTH
  function automatic logic [TAG_W-1:0] age_of(input logic [TAG_W-1:0] h,
                                               input logic [TAG_W-1:0] t);
    return t - h;
  endfunction

  function automatic logic [TAG_W-1:0] tag_inc(input logic [TAG_W-1:0] t);
    return t + TAG_W'(1);
  endfunction

  logic [TAG_W-1:0] head, tail;
  logic [CNT_W-1:0] count;
  slot_t            slots [DEPTH];
  slot_t            head_slot, flt_slot;

  logic pop, drop, fault_hit, alloc;
  logic [DEPTH-1:0] kill_v, alloc_v, retire_v, cmp_v, xl_v, flt_v;

  assign head_slot = slots[head];
  assign flt_slot  = slots[xl_fault_tag];

  pac_head_arb u_arb (
    .hs       (head_slot),
    .ext_mode (ext_mode),
    .grant    (pa_valid),
    .drop     (drop)
  );

  assign pop       = pa_valid || drop;
  assign pa_tag    = head;
  assign dec_ready = (count != FULL_CNT);
  assign dec_tag   = tail;
  assign fault_hit = xl_fault_valid && flt_slot.vld && flt_slot.mem &&
                     !flt_slot.xld && !flt_slot.flt &&
                     !(pop && (xl_fault_tag == head));
  assign alloc     = dec_valid && dec_ready && !fault_hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [TAG_W-1:0] ID = TAG_W'(i);
    assign cmp_v[i]    = cmp_valid && (cmp_tag == ID);
    assign xl_v[i]     = xl_done_valid && (xl_done_tag == ID);
    assign flt_v[i]    = fault_hit && (xl_fault_tag == ID);
    assign alloc_v[i]  = alloc && (tail == ID);
    assign retire_v[i] = pop && (head == ID);
    assign kill_v[i]   = fault_hit && slots[i].vld &&
                         (age_of(head, ID) > age_of(head, xl_fault_tag));
    pac_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc     (alloc_v[i]),
      .alloc_mem (dec_mem),
      .cmp_hit   (cmp_v[i]),
      .xl_hit    (xl_v[i]),
      .flt_set   (flt_v[i]),
      .kill      (kill_v[i]),
      .retire    (retire_v[i]),
      .q         (slots[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head    <= '0;
      tail    <= '0;
      count   <= '0;
      flush   <= 1'b0;
      exc_tag <= '0;
    end else begin
      flush <= fault_hit;
      if (fault_hit) exc_tag <= xl_fault_tag;
      if (pop) head <= tag_inc(head);
      if (fault_hit) begin
        tail  <= tag_inc(xl_fault_tag);
        count <= CNT_W'(age_of(head, xl_fault_tag)) + CNT_W'(1) - CNT_W'(pop);
      end else begin
        if (alloc) tail <= tag_inc(tail);
        count <= count + CNT_W'(alloc) - CNT_W'(pop);
      end
    end
  end

  a_r2_full_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready && !fault_hit) |=> (tail == $past(tail)));
  a_r3_head_steps: assert property (@(posedge clk) disable iff (!rst_n)
    pa_valid |=> (head == tag_inc($past(head))));
  a_r3_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !(pa_valid && drop));
  a_r6_ext_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_valid && ext_mode && head_slot.mem) |-> head_slot.xld);
  a_r7_flush_next: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hit |=> (flush && (exc_tag == $past(xl_fault_tag))));
  a_r7_tail_restart: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hit |=> (tail == tag_inc($past(xl_fault_tag))));
  a_r11_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !pa_valid);
endmodule

// File: tb/test_putaway_commit_ctrl.sv
`timescale 1ns/1ps
module test_putaway_commit_ctrl;
  localparam int D  = 8;
  localparam int TW = $clog2(D);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ext_mode, dec_valid, dec_mem, dec_ready;
  logic [TW-1:0] dec_tag, cmp_tag, xl_done_tag, xl_fault_tag, pa_tag, exc_tag;
  logic cmp_valid, xl_done_valid, xl_fault_valid, pa_valid, flush;

  putaway_commit_ctrl #(.DEPTH(D)) i_putaway_commit_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode),
    .dec_valid(dec_valid), .dec_mem(dec_mem), .dec_ready(dec_ready), .dec_tag(dec_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .xl_done_valid(xl_done_valid), .xl_done_tag(xl_done_tag),
    .xl_fault_valid(xl_fault_valid), .xl_fault_tag(xl_fault_tag),
    .pa_valid(pa_valid), .pa_tag(pa_tag), .flush(flush), .exc_tag(exc_tag)
  );

  int total = 0, bad = 0;
  bit bv[D], bm[D], be[D], bx[D], bf[D];
  int bhead = 0, btail = 0, bcount = 0, pa_seen = 0;

  function automatic int agef(int h, int t);
    return (t - h + D) % D;
  endfunction

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic clr(int i);
    bv[i] = 0; bm[i] = 0; be[i] = 0; bx[i] = 0; bf[i] = 0;
  endtask

  // one cycle: drive at negedge, check state outputs, update model at posedge
  task automatic tick(bit dv, bit dm, bit cv, int ct, bit xv, int xt,
                      bit fv, int ft, string rq);
    int hd;
    bit egr, edr, efh, al;
    dec_valid = dv; dec_mem = dm;
    cmp_valid = cv; cmp_tag = TW'(ct);
    xl_done_valid = xv; xl_done_tag = TW'(xt);
    xl_fault_valid = fv; xl_fault_tag = TW'(ft);
    hd  = bhead;
    egr = bv[hd] && be[hd] && !bf[hd] && (!bm[hd] || !ext_mode || bx[hd]);
    edr = bv[hd] && bf[hd];
    chk(pa_valid == egr, rq, "pa_valid", int'(pa_valid), int'(egr));
    if (egr) chk(int'(pa_tag) == hd, rq, "pa_tag", int'(pa_tag), hd);
    chk(dec_ready == (bcount < D), rq, "dec_ready", int'(dec_ready), int'(bcount < D));
    if (bcount < D) chk(int'(dec_tag) == btail, rq, "dec_tag", int'(dec_tag), btail);
    efh = fv && bv[ft] && bm[ft] && !bx[ft] && !bf[ft] && !((egr || edr) && ft == hd);
    al  = dv && (bcount < D) && !efh;
    @(posedge clk);
    if (cv && bv[ct]) be[ct] = 1;
    if (xv && bv[xt]) bx[xt] = 1;
    if (egr) pa_seen++;
    if (efh) begin
      for (int i = 0; i < D; i++)
        if (bv[i] && agef(hd, i) > agef(hd, ft)) clr(i);
      bf[ft] = 1;
    end
    if (egr || edr) begin
      clr(hd);
      bhead = (hd + 1) % D;
    end
    if (efh) begin
      btail  = (ft + 1) % D;
      bcount = agef(hd, ft) + 1 - ((egr || edr) ? 1 : 0);
    end else begin
      if (al) begin
        clr(btail); bv[btail] = 1; bm[btail] = dm;
        btail = (btail + 1) % D;
        bcount++;
      end
      if (egr || edr) bcount--;
    end
    @(negedge clk);
    chk(flush == efh, rq, "flush", int'(flush), int'(efh));
    if (efh) chk(int'(exc_tag) == ft, rq, "exc_tag", int'(exc_tag), ft);
  endtask

  task automatic idle(int n, string rq);
    for (int k = 0; k < n; k++) tick(0, 0, 0, 0, 0, 0, 0, 0, rq);
  endtask

  task automatic drain(string rq);
    for (int k = 0; k < 20 && bcount > 0; k++) tick(0, 0, 0, 0, 0, 0, 0, 0, rq);
    chk(bcount == 0, rq, "drained", bcount, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t0, mask, a, b, start;
    rst_n = 0; ext_mode = 0; dec_valid = 0; dec_mem = 0;
    cmp_valid = 0; cmp_tag = '0; xl_done_valid = 0; xl_done_tag = '0;
    xl_fault_valid = 0; xl_fault_tag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(dec_ready == 1'b1, "R1", "dec_ready", int'(dec_ready), 1);
    chk(dec_tag == '0, "R1", "dec_tag", int'(dec_tag), 0);
    chk(pa_valid == 1'b0, "R1", "pa_valid", int'(pa_valid), 0);
    chk(flush == 1'b0, "R1", "flush", int'(flush), 0);
    idle(3, "R11");

    // sweep: mixes x completion permutations x both modes (R2, R3, R5, R6)
    for (int md = 0; md < 2; md++) begin
      ext_mode = md[0];
      for (int tr = 0; tr < 24; tr++) begin
        mask = (tr * 37 + 11) & 255;
        a = 2 * (tr % 4) + 1;
        b = tr % D;
        start = pa_seen;
        for (int k = 0; k < D; k++) tick(1, mask[k], 0, 0, 0, 0, 0, 0, "R2");
        chk(dec_ready == 1'b0, "R2", "full dec_ready", int'(dec_ready), 0);
        tick(1, 1, 0, 0, 0, 0, 0, 0, "R2");
        for (int j = 0; j < D; j++)
          tick(0, 0, 1, (j * a + b) % D, 1, (j * (a + 2) + b + 3) % D, 0, 0,
               md ? "R6" : "R5");
        drain("R3");
        chk(pa_seen - start == D, "R3", "putaway count", pa_seen - start, D);
      end
    end

    // R5 vs R6: memory op completes, translation withheld
    ext_mode = 0; t0 = btail;
    tick(1, 1, 0, 0, 0, 0, 0, 0, "R5");
    tick(0, 0, 1, t0, 0, 0, 0, 0, "R5");
    chk(pa_valid == 1'b1, "R5", "mem without xl granted", int'(pa_valid), 1);
    drain("R5");
    ext_mode = 1; t0 = btail;
    tick(1, 1, 0, 0, 0, 0, 0, 0, "R6");
    tick(1, 0, 1, t0, 0, 0, 0, 0, "R6");
    tick(0, 0, 1, (t0 + 1) % D, 0, 0, 0, 0, "R6");
    idle(2, "R6");
    chk(pa_valid == 1'b0, "R6", "ALU behind untranslated mem", int'(pa_valid), 0);
    tick(0, 0, 0, 0, 1, t0, 0, 0, "R6");
    drain("R6");

    // R4: stale reports for an unoccupied tag
    t0 = btail;
    tick(0, 0, 1, t0, 1, t0, 0, 0, "R4");
    tick(1, 1, 0, 0, 0, 0, 0, 0, "R4");
    idle(2, "R4");
    chk(pa_valid == 1'b0, "R4", "stale report ignored", int'(pa_valid), 0);
    tick(0, 0, 1, t0, 1, t0, 0, 0, "R4");
    drain("R4");

    // R7, R8, R10: fault on a younger memory slot, decode in the same cycle
    t0 = btail;
    tick(1, 0, 0, 0, 0, 0, 0, 0, "R7");
    tick(1, 1, 0, 0, 0, 0, 0, 0, "R7");
    tick(1, 0, 0, 0, 0, 0, 0, 0, "R7");
    tick(1, 0, 1, t0, 0, 0, 0, 0, "R7");
    tick(0, 0, 1, (t0 + 2) % D, 0, 0, 0, 0, "R7");
    tick(0, 0, 1, (t0 + 3) % D, 0, 0, 0, 0, "R7");
    tick(0, 0, 1, (t0 + 1) % D, 0, 0, 0, 0, "R7");
    tick(1, 0, 0, 0, 0, 0, 1, (t0 + 1) % D, "R10");
    chk(int'(dec_tag) == (t0 + 2) % D, "R7", "restart tag", int'(dec_tag), (t0 + 2) % D);
    idle(3, "R8");
    chk(bcount == 0, "R8", "faulted slot removed", bcount, 0);

    // R9: faults that must be ignored
    t0 = btail;
    tick(1, 0, 0, 0, 0, 0, 0, 0, "R9");
    tick(1, 1, 0, 0, 0, 0, 1, t0, "R9");
    tick(0, 0, 0, 0, 1, (t0 + 1) % D, 1, (t0 + 4) % D, "R9");
    tick(0, 0, 0, 0, 0, 0, 1, (t0 + 1) % D, "R9");
    tick(0, 0, 1, t0, 0, 0, 0, 0, "R9");
    tick(0, 0, 1, (t0 + 1) % D, 0, 0, 0, 0, "R9");
    drain("R9");
    ext_mode = 0; t0 = btail;
    tick(1, 1, 0, 0, 0, 0, 0, 0, "R9");
    tick(0, 0, 1, t0, 0, 0, 0, 0, "R9");
    tick(0, 0, 0, 0, 0, 0, 1, t0, "R9");
    drain("R9");
    idle(2, "R11");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule